// File: doc/BRIEF.md
# Three-Channel Pulse-Link Receiver with Silence Default

This block sits on the receive side of a pulse-coded isolation link and serves three independent data channels. Each channel has two pulse lines: one that drives the channel high and one that drives it low. A per-channel bistable element holds the last decoded level between pulses, so a static input level is carried across the link only as occasional pulses.

A single watchdog watches all pulse lines together. When every line has stayed quiet for a programmable number of cycles, the block assumes the sending side is unpowered or disabled. It then replaces all channel outputs with a default level. A control input chooses that level, and a separate flag tells the block that the control input is left floating. The first pulse that arrives afterwards restarts normal operation at once.

A two-bit receive-side supply code sets the output stage. When the supply is off, the outputs are released. In the low supply band, the outputs are driven low. When the supply is good, the outputs show the decoded or default data. If both pulse lines of a channel fire in the same cycle, the channel keeps its level and reports a one-cycle error.

Top module: `iso_rx_decoder`

## Requirements
- R1: A rising-pulse on a channel with no falling-pulse in the same cycle makes that channel's held level 1 from the next clock edge.
- R2: A falling-pulse on a channel with no rising-pulse in the same cycle makes that channel's held level 0 from the next clock edge.
- R3: When both pulse lines of a channel fire in the same cycle, the held level is unchanged and that channel's `pulse_clash` bit is 1 for exactly the following cycle. Otherwise `pulse_clash` is 0.
- R4: If TIMEOUT consecutive clock edges pass with no pulse on any line after the edge that took the last pulse, the watchdog expires at that TIMEOUT-th edge and every output shows the default level. After TIMEOUT-1 such edges, the outputs still show the held levels.
- R5: A pulse on any line of any channel restarts the watchdog window for all channels.
- R6: The default level is 1 when `dflt_hi` is 1 or `dflt_float` is 1. It is 0 only when both are 0.
- R7: While the watchdog is not expired, `dflt_hi` and `dflt_float` have no effect on the outputs.
- R8: After reset, the watchdog starts expired, every held level is 0, and `pulse_clash` is 0. The outputs show the default level until the first pulse arrives.
- R9: At the edge that takes the first pulse after expiry, the watchdog clears. From then on, every channel shows its held level, including channels that kept a level from before the silence.
- R10: The supply code sets the output stage. With `rx_supply` = 2'b00, `out_en` is 0 and `data_out` is 0. With 2'b01, `out_en` is 1 and `data_out` is 0. With 2'b10 or 2'b11, `out_en` is 1 and `data_out` carries the data. The supply code acts on the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| rise_pulse | input | NCH | Per-channel pulse that drives the channel high |
| fall_pulse | input | NCH | Per-channel pulse that drives the channel low |
| dflt_hi | input | 1 | Default-level select: 1 selects high |
| dflt_float | input | 1 | Set when the default-level select is not connected; forces high |
| rx_supply | input | 2 | Receive-side supply status code |
| data_out | output | NCH | Per-channel output data |
| out_en | output | 1 | Output drive enable; 0 means high impedance |
| pulse_clash | output | NCH | One-cycle flag for simultaneous rise and fall pulses |

## Verification
A held level that is wrong shows up on `data_out` at the first edge after the faulty pulse, as long as the supply is good and the watchdog is live. The same wrong level stays hidden while the watchdog is expired and reappears when pulses resume. A watchdog counter that is off by one moves the switch to the default level by one cycle. For that reason, the checks sample both the TIMEOUT-1 and the TIMEOUT edge after the last pulse, and they check again after a reload from a different channel. A supply decode fault is visible right away, with no clock edge, on `out_en` or `data_out`.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

  typedef enum logic [1:0] {
    SUP_OFF  = 2'b00,
    SUP_LOW  = 2'b01,
    SUP_GOOD = 2'b10
  } sup_mode_t;

  // Bit 1 set means the supply is in its working range.
  function automatic sup_mode_t sup_decode(input logic [1:0] code);
    if (code[1])       return SUP_GOOD;
    else if (code[0])  return SUP_LOW;
    else               return SUP_OFF;
  endfunction

  // A floating select pin reads as high.
  function automatic logic dflt_level(input logic sel_hi, input logic floating);
    return sel_hi | floating;
  endfunction

  // Next held level; a clash keeps the old level.
  function automatic logic hold_next(input logic q, input logic rise, input logic fall);
    if (rise && !fall)      return 1'b1;
    else if (fall && !rise) return 1'b0;
    else                    return q;
  endfunction

endpackage

// File: rtl/iso_rx_hold.sv
module iso_rx_hold
  import iso_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  output logic level_q,
  output logic clash_q
);

  logic clash_now;
  assign clash_now = rise_i & fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      clash_q <= 1'b0;
    end else begin
      level_q <= hold_next(level_q, rise_i, fall_i);
      clash_q <= clash_now;
    end
  end

endmodule

// File: rtl/iso_rx_watchdog.sv
module iso_rx_watchdog #(
  parameter int TIMEOUT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic expired
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT);

  logic [CW-1:0] remain_q;

  // Reset leaves the window empty, so the default shows until the first pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 remain_q <= '0;
    else if (activity)          remain_q <= RELOAD;
    else if (remain_q != '0)    remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/iso_rx_outstage.sv
module iso_rx_outstage
  import iso_rx_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [1:0]     supply_code,
  input  logic           use_default,
  input  logic           default_bit,
  input  logic [NCH-1:0] held,
  output logic [NCH-1:0] data_o,
  output logic           drive_o
);

  sup_mode_t mode;
  logic [NCH-1:0] chosen;

  assign mode   = sup_decode(supply_code);
  assign chosen = use_default ? {NCH{default_bit}} : held;

  always_comb begin
    unique case (mode)
      SUP_OFF:  begin drive_o = 1'b0; data_o = '0;     end
      SUP_LOW:  begin drive_o = 1'b1; data_o = '0;     end
      default:  begin drive_o = 1'b1; data_o = chosen; end
    endcase
  end

endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
  import iso_rx_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int TIMEOUT = 500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise_pulse,
  input  logic [NCH-1:0] fall_pulse,
  input  logic           dflt_hi,
  input  logic           dflt_float,
  input  logic [1:0]     rx_supply,
  output logic [NCH-1:0] data_out,
  output logic           out_en,
  output logic [NCH-1:0] pulse_clash
);

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] latch_q;
  logic           any_pulse;
  logic           wd_expired;
  logic           dflt_bit;

  assign any_pulse = |(rise_pulse | fall_pulse);
  assign dflt_bit  = dflt_level(dflt_hi, dflt_float);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    iso_rx_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise_pulse[ch]),
      .fall_i  (fall_pulse[ch]),
      .level_q (latch_q[ch]),
      .clash_q (pulse_clash[ch])
    );
  end

  iso_rx_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (any_pulse),
    .expired  (wd_expired)
  );

  iso_rx_outstage #(.NCH(NCH)) u_out (
    .supply_code (rx_supply),
    .use_default (wd_expired),
    .default_bit (dflt_bit),
    .held        (latch_q),
    .data_o      (data_out),
    .drive_o     (out_en)
  );

endmodule

// File: rtl/iso_rx_decoder_chk.sv
module iso_rx_decoder_chk #(
  parameter int NCH     = 3,
  parameter int TIMEOUT = 500
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] rise_pulse,
  input logic [NCH-1:0] fall_pulse,
  input logic           dflt_hi,
  input logic           dflt_float,
  input logic [1:0]     rx_supply,
  input logic [NCH-1:0] data_out,
  input logic           out_en,
  input logic [NCH-1:0] pulse_clash,
  input logic [NCH-1:0] latch_q,
  input logic           wd_expired
);

  localparam int SW = $clog2(TIMEOUT + 1);
  localparam logic [SW-1:0] SMAX = SW'(TIMEOUT);

  // Count quiet edges upward; saturate at TIMEOUT.
  logic [SW-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              quiet_q <= SMAX;
    else if (|(rise_pulse | fall_pulse))     quiet_q <= '0;
    else if (quiet_q != SMAX)                quiet_q <= quiet_q + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R1
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_pulse[i] && !fall_pulse[i]) |=> latch_q[i]);
    // R2
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_pulse[i] && !rise_pulse[i]) |=> !latch_q[i]);
    // R3
    clash_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_pulse[i] && fall_pulse[i]) |=> (pulse_clash[i] && $stable(latch_q[i])));
    // R3
    clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse[i] && fall_pulse[i]) |=> !pulse_clash[i]);
  end

  // R4
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired == (quiet_q == SMAX));
  // R5
  pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_pulse | fall_pulse)) |=> !wd_expired);
  // R6
  default_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_supply[1] && wd_expired) |-> (data_out == {NCH{dflt_hi | dflt_float}}));
  // R7
  live_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_supply[1] && !wd_expired) |-> (data_out == latch_q));
  // R10
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_supply == 2'b00) |-> (!out_en && data_out == '0));
  // R10
  supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_supply == 2'b01) |-> (out_en && data_out == '0));

endmodule

bind iso_rx_decoder iso_rx_decoder_chk #(.NCH(NCH), .TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise_pulse  (rise_pulse),
  .fall_pulse  (fall_pulse),
  .dflt_hi     (dflt_hi),
  .dflt_float  (dflt_float),
  .rx_supply   (rx_supply),
  .data_out    (data_out),
  .out_en      (out_en),
  .pulse_clash (pulse_clash),
  .latch_q     (latch_q),
  .wd_expired  (wd_expired)
);

// File: tb/iso_rx_decoder_bench.sv
`timescale 1ns/1ps
module iso_rx_decoder_bench;

  localparam int NCH = 3;
  localparam int TO  = 16;
  localparam int NV  = 13;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] rise_pulse = '0;
  logic [NCH-1:0] fall_pulse = '0;
  logic           dflt_hi = 1'b1;
  logic           dflt_float = 1'b0;
  logic [1:0]     rx_supply = 2'b10;
  logic [NCH-1:0] data_out;
  logic           out_en;
  logic [NCH-1:0] pulse_clash;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  iso_rx_decoder #(.NCH(NCH), .TIMEOUT(TO)) u_iso_rx_decoder (
    .clk(clk), .rst_n(rst_n), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
    .dflt_hi(dflt_hi), .dflt_float(dflt_float), .rx_supply(rx_supply),
    .data_out(data_out), .out_en(out_en), .pulse_clash(pulse_clash)
  );

  // Vector: rise[16:14] fall[13:11] hi[10] float[9] sup[8:7] exp_data[6:4] exp_en[3] exp_clash[2:0]
  localparam logic [16:0] VEC [NV] = '{
    {3'b000, 3'b000, 1'b1, 1'b0, 2'b10, 3'b111, 1'b1, 3'b000}, // R8 R6 default high
    {3'b000, 3'b000, 1'b0, 1'b0, 2'b10, 3'b000, 1'b1, 3'b000}, // R6 default low
    {3'b000, 3'b000, 1'b0, 1'b1, 2'b10, 3'b111, 1'b1, 3'b000}, // R6 floating select
    {3'b001, 3'b000, 1'b0, 1'b0, 2'b10, 3'b001, 1'b1, 3'b000}, // R1 R9 ch0 rise
    {3'b010, 3'b000, 1'b0, 1'b0, 2'b10, 3'b011, 1'b1, 3'b000}, // R1 ch1 rise
    {3'b000, 3'b001, 1'b1, 1'b0, 2'b10, 3'b010, 1'b1, 3'b000}, // R2 R7 ch0 fall, select ignored
    {3'b100, 3'b100, 1'b0, 1'b1, 2'b10, 3'b010, 1'b1, 3'b100}, // R3 R7 clash on ch2
    {3'b000, 3'b000, 1'b0, 1'b0, 2'b10, 3'b010, 1'b1, 3'b000}, // R3 flag lasts one cycle
    {3'b000, 3'b000, 1'b0, 1'b0, 2'b01, 3'b000, 1'b1, 3'b000}, // R10 low band
    {3'b000, 3'b000, 1'b0, 1'b0, 2'b00, 3'b000, 1'b0, 3'b000}, // R10 off
    {3'b000, 3'b000, 1'b0, 1'b0, 2'b11, 3'b010, 1'b1, 3'b000}, // R10 code 11 good
    {3'b110, 3'b001, 1'b0, 1'b0, 2'b10, 3'b110, 1'b1, 3'b000}, // R1 R2 mixed
    {3'b011, 3'b100, 1'b0, 1'b0, 2'b10, 3'b011, 1'b1, 3'b000}  // R1 R2 mixed
  };

  task automatic check(input string req, input logic [NCH-1:0] exp_d,
                       input logic exp_e, input logic [NCH-1:0] exp_c);
    n_chk++;
    if (data_out !== exp_d || out_en !== exp_e || pulse_clash !== exp_c) begin
      n_bad++;
      $display("FAIL %s: data=%b en=%b clash=%b expected data=%b en=%b clash=%b",
               req, data_out, out_en, pulse_clash, exp_d, exp_e, exp_c);
    end
  endtask

  task automatic step(input logic [NCH-1:0] r, input logic [NCH-1:0] f);
    rise_pulse = r;
    fall_pulse = f;
    @(posedge clk);
    @(negedge clk);
    rise_pulse = '0;
    fall_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 in reset", 3'b111, 1'b1, 3'b000);
    rst_n = 1'b1;
    idle(2);
    check("R8 after reset", 3'b111, 1'b1, 3'b000);

    for (int v = 0; v < NV; v++) begin
      rise_pulse = VEC[v][16:14];
      fall_pulse = VEC[v][13:11];
      dflt_hi    = VEC[v][10];
      dflt_float = VEC[v][9];
      rx_supply  = VEC[v][8:7];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R1-table vector %0d", v), VEC[v][6:4], VEC[v][3], VEC[v][2:0]);
    end
    rise_pulse = '0; fall_pulse = '0;
    dflt_hi = 1'b0; dflt_float = 1'b0; rx_supply = 2'b10;

    // R4: last pulse at the final table edge
    idle(TO - 1);
    check("R4 one edge before expiry", 3'b011, 1'b1, 3'b000);
    idle(1);
    check("R4 expiry to default", 3'b000, 1'b1, 3'b000);

    // R5: reload from another channel extends the window
    step(3'b000, 3'b100);
    check("R9 resume on ch2 fall", 3'b011, 1'b1, 3'b000);
    idle(9);
    step(3'b010, 3'b000);
    idle(TO - 1);
    check("R5 reload kept window live", 3'b011, 1'b1, 3'b000);
    idle(1);
    check("R5 expiry after reload", 3'b000, 1'b1, 3'b000);

    // R9: resume with high default; stale ch0 level reappears
    dflt_hi = 1'b1;
    @(negedge clk);
    check("R6 default high while expired", 3'b111, 1'b1, 3'b000);
    step(3'b000, 3'b010);
    check("R9 first pulse restores levels", 3'b001, 1'b1, 3'b000);
    check("R7 select ignored live", 3'b001, 1'b1, 3'b000);

    // R8: reset mid-run clears held levels and expires watchdog
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset mid-run", 3'b111, 1'b1, 3'b000);
    rst_n = 1'b1;
    dflt_hi = 1'b0;
    idle(1);
    check("R8 default until pulse", 3'b000, 1'b1, 3'b000);
    step(3'b100, 3'b000);
    check("R8 levels cleared by reset", 3'b100, 1'b1, 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule